// File: doc/BRIEF.md
# Segmented Global Virtual Address Generator

This block sits in the address stage of a load/store unit. It reads a general-register base value and combines it with one of two things: a scaled index register, or a signed displacement. The displacement is a 5-bit field in the short forms and a wider immediate in the long form. The result of that addition is the offset. The block then joins the offset to a 64-bit space identifier held in an eight-entry space register file. The join is a plain bitwise OR, not an addition, so software keeps space bits and offset bits apart. The result is the global virtual address sent to memory.

The instruction's 2-bit space field normally names space register 1, 2 or 3 directly. A zero field hands the choice to the top two bits of the base value, which select space register 4 to 7. The block also handles base-register update addressing. In pre-modify mode the access uses the new offset. In post-modify mode the access uses the old base. In both cases the offset is returned as a writeback value for the base register. Two mode flags adjust the result. Wide mode clears the two highest bits of the extended offset. Physical mode skips the space identifier entirely.

The request path is a valid/ready stream with no storage. The block is purely combinational from request to result, so `out_valid` mirrors `in_valid` and `in_ready` mirrors `out_ready`. A request is consumed in the cycle where `in_valid` and `out_ready` are both high. The upstream stage holds its request and all operands steady while `out_ready` is low. The only state is the space register file. It resets to zero and is written on the clock edge through its own port.

Top module: `gva_gen`

## Requirements
- R1: With `form`=0 (indexed), offset = base + (index << s) modulo 2^REG_W, where the index register number is `insn[20:16]`, and s is `size_log2` when `insn[13]` is 1 or 0 when it is 0.
- R2: With `form`=1 (short displacement), offset = base + the two's-complement 5-bit value in `insn[20:16]`, sign-extended and wrapping modulo 2^REG_W.
- R3: With `form`=2 (long immediate), offset = base + the sign-extended `long_imm`; when `insn[5]` is 1 a negative immediate gives post-modify and a non-negative one gives pre-modify; when `insn[5]` is 0 there is no modification.
- R4: Modification is requested by `insn[5]`=1; in short form `insn[13]`=1 means pre-modify and 0 means post-modify; in indexed form a request is always post-modify.
- R5: The memory offset is the unmodified base for post-modify, and the computed offset for pre-modify or no modification.
- R6: When a modification is requested with `in_valid` high, `wb_en` is 1, `wb_reg` equals the base register number `insn[25:21]` and `wb_data` is the offset; otherwise `wb_en` is 0.
- R7: With `form`=3 (byte store), the offset is formed as in R2, `insn[13]` is ignored, a request by `insn[5]` is post-modify, and `wb_data` is the offset with bits 1:0 cleared.
- R8: Register number 0 reads as zero for both base and index, whatever `base_val` or `idx_val` carry; this zero base also drives the implicit space choice.
- R9: A nonzero space field `insn[15:14]` selects space register 1, 2 or 3 by its value, regardless of the base bits.
- R10: A zero space field selects space register 4 + base[REG_W-1:REG_W-2].
- R11: Outside physical mode, `gva` = zero-extended memory offset OR the selected space register (bitwise, no carry).
- R12: With `wide_mode`=1, bits GVA_W-1:GVA_W-2 of the extended memory offset are cleared before the space value is ORed in.
- R13: With `phys_mode`=1, `gva` is the extended (and, in wide mode, masked) memory offset, with no space bits.
- R14: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in the same cycle; space registers reset to zero and take `sr_wdata` at index `sr_waddr` on a rising edge with `sr_we` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the space register file |
| rst_n | input | 1 | Active-low asynchronous reset |
| sr_we | input | 1 | Space register write enable |
| sr_waddr | input | 3 | Space register write index |
| sr_wdata | input | GVA_W | Space register write data |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| insn | input | 32 | Instruction word carrying the address fields |
| form | input | 2 | Addressing form: 0 indexed, 1 short, 2 long, 3 byte store |
| size_log2 | input | 2 | Log2 of the access size, used as index scale |
| long_imm | input | IMM_W | Assembled signed immediate for the long form |
| base_val | input | REG_W | Contents of the named base register |
| idx_val | input | REG_W | Contents of the named index register |
| wide_mode | input | 1 | Clear the top two extended offset bits |
| phys_mode | input | 1 | Physical addressing, no space bits |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream can take the result |
| gva | output | GVA_W | Global virtual address for memory |
| wb_en | output | 1 | Base register writeback requested |
| wb_reg | output | 5 | Base register number to write |
| wb_data | output | REG_W | New base register value |

## Verification
The bench builds two copies of the block. The main one keeps the default 32-bit registers, so the space identifier and the offset occupy separate halves of the address. There every displacement sign, pre/post choice, implicit space index and the wrap of the offset adder can be seen directly in `gva`. A second copy uses 64-bit registers. Only at that width does the offset reach the top two address bits, so only there does wide mode have a visible effect. The same copy shows the implicit space choice being made from bit 63 and bit 62 of the base.

// File: rtl/gva_pkg.sv
package gva_pkg;

  typedef enum logic [1:0] {
    FORM_INDEXED = 2'd0,
    FORM_SHORT   = 2'd1,
    FORM_LONG    = 2'd2,
    FORM_BSTORE  = 2'd3
  } am_form_e;

  typedef enum logic [1:0] {
    MOD_NONE = 2'd0,
    MOD_PRE  = 2'd1,
    MOD_POST = 2'd2
  } mod_kind_e;

  localparam int REGNUM_W  = 5;
  localparam int SPF_W     = 2;
  localparam int SR_COUNT  = 8;
  localparam int SR_AW     = $clog2(SR_COUNT);
  localparam int SP_LSB    = 14;
  localparam int RB_LSB    = 21;
  localparam int F5_LSB    = 16;
  localparam int ORDER_BIT = 13;
  localparam int MOD_BIT   = 5;

endpackage

// File: rtl/gva_field_decode.sv
module gva_field_decode
  import gva_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int IMM_W = 14
) (
  input  logic [31:0]          insn,
  input  am_form_e             form,
  input  logic [IMM_W-1:0]     long_imm,
  input  logic [1:0]           size_log2,
  output logic [REGNUM_W-1:0]  base_num,
  output logic [REGNUM_W-1:0]  idx_num,
  output logic [SPF_W-1:0]     sp_field,
  output logic [REG_W-1:0]     disp,
  output logic                 use_index,
  output logic [1:0]           shift,
  output mod_kind_e            mod_kind,
  output logic                 align_wb
);

  logic [4:0] f5;
  logic       order_b;
  logic       mod_b;
  logic [REG_W-1:0] disp5_x;
  logic [REG_W-1:0] imm_x;
  logic       unused_bits;

  assign base_num = insn[RB_LSB +: REGNUM_W];
  assign f5       = insn[F5_LSB +: 5];
  assign idx_num  = f5;
  assign sp_field = insn[SP_LSB +: SPF_W];
  assign order_b  = insn[ORDER_BIT];
  assign mod_b    = insn[MOD_BIT];
  assign disp5_x  = {{(REG_W-5){f5[4]}}, f5};
  assign imm_x    = {{(REG_W-IMM_W){long_imm[IMM_W-1]}}, long_imm};
  assign unused_bits = ^{insn[31:26], insn[12:6], insn[4:0]};

  always_comb begin
    use_index = 1'b0;
    shift     = 2'd0;
    disp      = '0;
    mod_kind  = MOD_NONE;
    align_wb  = 1'b0;
    unique case (form)
      FORM_INDEXED: begin
        use_index = 1'b1;
        shift     = order_b ? size_log2 : 2'd0;
        mod_kind  = mod_b ? MOD_POST : MOD_NONE;
      end
      FORM_SHORT: begin
        disp     = disp5_x;
        mod_kind = mod_b ? (order_b ? MOD_PRE : MOD_POST) : MOD_NONE;
      end
      FORM_LONG: begin
        disp     = imm_x;
        mod_kind = mod_b ? (long_imm[IMM_W-1] ? MOD_POST : MOD_PRE) : MOD_NONE;
      end
      FORM_BSTORE: begin
        disp     = disp5_x;
        mod_kind = mod_b ? MOD_POST : MOD_NONE;
        align_wb = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/gva_offset_calc.sv
module gva_offset_calc #(
  parameter int REG_W = 32
) (
  input  logic [REG_W-1:0] base_eff,
  input  logic [REG_W-1:0] idx_eff,
  input  logic             use_index,
  input  logic [1:0]       shift,
  input  logic [REG_W-1:0] disp,
  output logic [REG_W-1:0] offset
);

  logic [REG_W-1:0] scaled;
  logic [REG_W-1:0] addend;

  assign scaled = idx_eff << shift;
  assign addend = use_index ? scaled : disp;
  assign offset = base_eff + addend;

endmodule

// File: rtl/gva_space_rf.sv
module gva_space_rf
  import gva_pkg::*;
#(
  parameter int SPACE_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [SR_AW-1:0]   waddr,
  input  logic [SPACE_W-1:0] wdata,
  input  logic [SR_AW-1:0]   raddr_exp,
  input  logic [SR_AW-1:0]   raddr_imp,
  output logic [SPACE_W-1:0] rdata_exp,
  output logic [SPACE_W-1:0] rdata_imp
);

  logic [SPACE_W-1:0] regs [SR_COUNT];

  for (genvar g = 0; g < SR_COUNT; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[g] <= '0;
      end else if (we && (waddr == SR_AW'(g))) begin
        regs[g] <= wdata;
      end
    end
  end

  assign rdata_exp = regs[raddr_exp];
  assign rdata_imp = regs[raddr_imp];

  AST_SR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> regs[$past(waddr)] == $past(wdata)); // R14

endmodule

// File: rtl/gva_addr_form.sv
module gva_addr_form
  import gva_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int GVA_W = 64
) (
  input  logic [REG_W-1:0] base_eff,
  input  logic [REG_W-1:0] offset,
  input  mod_kind_e        mod_kind,
  input  logic [GVA_W-1:0] space,
  input  logic             wide_mode,
  input  logic             phys_mode,
  output logic [GVA_W-1:0] gva
);

  localparam logic [GVA_W-1:0] WIDE_MASK = {2'b00, {(GVA_W-2){1'b1}}};

  logic [REG_W-1:0] mem_ofs;
  logic [GVA_W-1:0] ext;
  logic [GVA_W-1:0] masked;

  assign mem_ofs = (mod_kind == MOD_POST) ? base_eff : offset;

  if (REG_W < GVA_W) begin : g_zext
    assign ext = {{(GVA_W-REG_W){1'b0}}, mem_ofs};
  end else begin : g_same
    assign ext = mem_ofs;
  end

  assign masked = wide_mode ? (ext & WIDE_MASK) : ext;
  assign gva    = phys_mode ? masked : (masked | space);

endmodule

// File: rtl/gva_gen.sv
module gva_gen
  import gva_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int IMM_W = 14,
  parameter int GVA_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sr_we,
  input  logic [2:0]       sr_waddr,
  input  logic [GVA_W-1:0] sr_wdata,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      insn,
  input  logic [1:0]       form,
  input  logic [1:0]       size_log2,
  input  logic [IMM_W-1:0] long_imm,
  input  logic [REG_W-1:0] base_val,
  input  logic [REG_W-1:0] idx_val,
  input  logic             wide_mode,
  input  logic             phys_mode,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [GVA_W-1:0] gva,
  output logic             wb_en,
  output logic [4:0]       wb_reg,
  output logic [REG_W-1:0] wb_data
);

  logic [REGNUM_W-1:0] base_num;
  logic [REGNUM_W-1:0] idx_num;
  logic [SPF_W-1:0]    sp_field;
  logic [REG_W-1:0]    disp;
  logic                use_index;
  logic [1:0]          shift;
  mod_kind_e           mod_kind;
  logic                align_wb;
  logic [REG_W-1:0]    base_eff;
  logic [REG_W-1:0]    idx_eff;
  logic [REG_W-1:0]    offset;
  logic [SR_AW-1:0]    ra_exp;
  logic [SR_AW-1:0]    ra_imp;
  logic [GVA_W-1:0]    sp_exp;
  logic [GVA_W-1:0]    sp_imp;
  logic [GVA_W-1:0]    space;
  am_form_e            form_e;

  assign form_e = am_form_e'(form);

  gva_field_decode #(.REG_W(REG_W), .IMM_W(IMM_W)) u_dec (
    .insn      (insn),
    .form      (form_e),
    .long_imm  (long_imm),
    .size_log2 (size_log2),
    .base_num  (base_num),
    .idx_num   (idx_num),
    .sp_field  (sp_field),
    .disp      (disp),
    .use_index (use_index),
    .shift     (shift),
    .mod_kind  (mod_kind),
    .align_wb  (align_wb)
  );

  assign base_eff = (base_num == '0) ? '0 : base_val;
  assign idx_eff  = (idx_num  == '0) ? '0 : idx_val;

  gva_offset_calc #(.REG_W(REG_W)) u_ofs (
    .base_eff  (base_eff),
    .idx_eff   (idx_eff),
    .use_index (use_index),
    .shift     (shift),
    .disp      (disp),
    .offset    (offset)
  );

  assign ra_exp = {1'b0, sp_field};
  assign ra_imp = {1'b1, base_eff[REG_W-1 -: 2]};

  gva_space_rf #(.SPACE_W(GVA_W)) u_srf (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (sr_we),
    .waddr     (sr_waddr),
    .wdata     (sr_wdata),
    .raddr_exp (ra_exp),
    .raddr_imp (ra_imp),
    .rdata_exp (sp_exp),
    .rdata_imp (sp_imp)
  );

  assign space = (sp_field != '0) ? sp_exp : sp_imp;

  gva_addr_form #(.REG_W(REG_W), .GVA_W(GVA_W)) u_form (
    .base_eff  (base_eff),
    .offset    (offset),
    .mod_kind  (mod_kind),
    .space     (space),
    .wide_mode (wide_mode),
    .phys_mode (phys_mode),
    .gva       (gva)
  );

  assign wb_en     = in_valid && (mod_kind != MOD_NONE);
  assign wb_reg    = base_num;
  assign wb_data   = align_wb ? {offset[REG_W-1:2], 2'b00} : offset;
  assign out_valid = in_valid;
  assign in_ready  = out_ready;

  AST_POST_USES_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && phys_mode && !wide_mode && mod_kind == MOD_POST)
      |-> gva[REG_W-1:0] == base_eff); // R5

  AST_PRE_USES_OFS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && phys_mode && !wide_mode && mod_kind != MOD_POST)
      |-> gva[REG_W-1:0] == offset); // R5

  AST_WB_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && form_e == FORM_BSTORE) |-> wb_data[1:0] == 2'b00); // R7

  AST_WB_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !wb_en); // R6

  AST_WIDE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && wide_mode && phys_mode) |-> gva[GVA_W-1 -: 2] == 2'b00); // R12

endmodule

// File: tb/gva_gen_test.sv
module gva_gen_test;

  typedef struct packed {
    logic [1:0]  form;
    logic [31:0] insn;
    logic [1:0]  size;
    logic [13:0] imm;
    logic [31:0] base;
    logic [31:0] idx;
    logic        wide;
    logic        phys;
    logic [63:0] gva;
    logic        wbe;
    logic [31:0] wbd;
    logic [3:0]  rq;
  } vec_t;

  function automatic logic [31:0] mk(input logic [1:0] sp, input logic [4:0] rb,
                                     input logic [4:0] f, input logic b13, input logic b5);
    return {6'b0, rb, f, sp, b13, 7'b0, b5, 5'b0};
  endfunction

  function automatic logic [63:0] sr_val(input int k);
    logic [63:0] v;
    v = 64'(k) << 40;
    if (k == 3) v = v | 64'hF0;
    return v;
  endfunction

  localparam int NV = 23;
  localparam vec_t TBL [NV] = '{
    // R1 indexed, scaled by size
    '{2'd0, mk(2'd1,5'd3,5'd4,1'b1,1'b0), 2'd2, 14'h0, 32'h1000, 32'h10, 1'b0, 1'b0, 64'h0000_0100_0000_1040, 1'b0, 32'h0, 4'd1},
    // R1 indexed, unscaled
    '{2'd0, mk(2'd2,5'd3,5'd4,1'b0,1'b0), 2'd2, 14'h0, 32'h100, 32'h8, 1'b0, 1'b0, 64'h0000_0200_0000_0108, 1'b0, 32'h0, 4'd1},
    // R4 indexed modify is post
    '{2'd0, mk(2'd1,5'd3,5'd4,1'b1,1'b1), 2'd3, 14'h0, 32'h2000, 32'h4, 1'b0, 1'b0, 64'h0000_0100_0000_2000, 1'b1, 32'h2020, 4'd4},
    // R8 index reg 0
    '{2'd0, mk(2'd1,5'd3,5'd0,1'b1,1'b0), 2'd2, 14'h0, 32'h500, 32'hFFFF, 1'b0, 1'b0, 64'h0000_0100_0000_0500, 1'b0, 32'h0, 4'd8},
    // R2 short negative
    '{2'd1, mk(2'd2,5'd3,5'h1D,1'b0,1'b0), 2'd0, 14'h0, 32'h100, 32'h0, 1'b0, 1'b0, 64'h0000_0200_0000_00FD, 1'b0, 32'h0, 4'd2},
    // R4 short pre
    '{2'd1, mk(2'd1,5'd3,5'h04,1'b1,1'b1), 2'd0, 14'h0, 32'h300, 32'h0, 1'b0, 1'b0, 64'h0000_0100_0000_0304, 1'b1, 32'h304, 4'd4},
    // R5 short post
    '{2'd1, mk(2'd1,5'd3,5'h18,1'b0,1'b1), 2'd0, 14'h0, 32'h300, 32'h0, 1'b0, 1'b0, 64'h0000_0100_0000_0300, 1'b1, 32'h2F8, 4'd5},
    // R3 long positive pre
    '{2'd2, mk(2'd1,5'd3,5'd0,1'b0,1'b1), 2'd0, 14'h0100, 32'h1000, 32'h0, 1'b0, 1'b0, 64'h0000_0100_0000_1100, 1'b1, 32'h1100, 4'd3},
    // R3 long negative post
    '{2'd2, mk(2'd2,5'd3,5'd0,1'b0,1'b1), 2'd0, 14'h3FE0, 32'h1000, 32'h0, 1'b0, 1'b0, 64'h0000_0200_0000_1000, 1'b1, 32'h0FE0, 4'd3},
    // R3 long negative no modify
    '{2'd2, mk(2'd1,5'd3,5'd0,1'b0,1'b0), 2'd0, 14'h3FE0, 32'h1000, 32'h0, 1'b0, 1'b0, 64'h0000_0100_0000_0FE0, 1'b0, 32'h0, 4'd3},
    // R7 byte store, bit13 ignored
    '{2'd3, mk(2'd1,5'd3,5'h06,1'b1,1'b1), 2'd0, 14'h0, 32'h1001, 32'h0, 1'b0, 1'b0, 64'h0000_0100_0000_1001, 1'b1, 32'h1004, 4'd7},
    // R10 implicit 6
    '{2'd1, mk(2'd0,5'd3,5'd0,1'b0,1'b0), 2'd0, 14'h0, 32'h8000_0010, 32'h0, 1'b0, 1'b0, 64'h0000_0600_8000_0010, 1'b0, 32'h0, 4'd10},
    // R10 implicit 7
    '{2'd1, mk(2'd0,5'd3,5'd0,1'b0,1'b0), 2'd0, 14'h0, 32'hC000_0000, 32'h0, 1'b0, 1'b0, 64'h0000_0700_C000_0000, 1'b0, 32'h0, 4'd10},
    // R10 implicit 5
    '{2'd1, mk(2'd0,5'd3,5'd0,1'b0,1'b0), 2'd0, 14'h0, 32'h4000_0004, 32'h0, 1'b0, 1'b0, 64'h0000_0500_4000_0004, 1'b0, 32'h0, 4'd10},
    // R10 implicit 4
    '{2'd1, mk(2'd0,5'd3,5'd0,1'b0,1'b0), 2'd0, 14'h0, 32'h0000_0004, 32'h0, 1'b0, 1'b0, 64'h0000_0400_0000_0004, 1'b0, 32'h0, 4'd10},
    // R11 OR not add
    '{2'd1, mk(2'd3,5'd3,5'd0,1'b0,1'b0), 2'd0, 14'h0, 32'h18, 32'h0, 1'b0, 1'b0, 64'h0000_0300_0000_00F8, 1'b0, 32'h0, 4'd11},
    // R13 physical
    '{2'd1, mk(2'd1,5'd3,5'd0,1'b0,1'b0), 2'd0, 14'h0, 32'h1234, 32'h0, 1'b0, 1'b1, 64'h0000_0000_0000_1234, 1'b0, 32'h0, 4'd13},
    // R13 physical post
    '{2'd1, mk(2'd1,5'd3,5'h18,1'b0,1'b1), 2'd0, 14'h0, 32'h300, 32'h0, 1'b0, 1'b1, 64'h0000_0000_0000_0300, 1'b1, 32'h2F8, 4'd13},
    // R8 base reg 0
    '{2'd1, mk(2'd1,5'd0,5'h05,1'b0,1'b0), 2'd0, 14'h0, 32'hDEAD, 32'h0, 1'b0, 1'b0, 64'h0000_0100_0000_0005, 1'b0, 32'h0, 4'd8},
    // R8 base reg 0 drives implicit choice
    '{2'd1, mk(2'd0,5'd0,5'd0,1'b0,1'b0), 2'd0, 14'h0, 32'hC000_0000, 32'h0, 1'b0, 1'b0, 64'h0000_0400_0000_0000, 1'b0, 32'h0, 4'd8},
    // R12 wide, no effect at 32 bits
    '{2'd1, mk(2'd1,5'd3,5'd0,1'b0,1'b0), 2'd0, 14'h0, 32'h1000, 32'h0, 1'b1, 1'b0, 64'h0000_0100_0000_1000, 1'b0, 32'h0, 4'd12},
    // R2 wrap
    '{2'd1, mk(2'd2,5'd3,5'h01,1'b0,1'b0), 2'd0, 14'h0, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0, 64'h0000_0200_0000_0000, 1'b0, 32'h0, 4'd2},
    // R9 explicit wins over base bits
    '{2'd1, mk(2'd2,5'd3,5'd0,1'b0,1'b0), 2'd0, 14'h0, 32'hC000_0000, 32'h0, 1'b0, 1'b0, 64'h0000_0200_C000_0000, 1'b0, 32'h0, 4'd9}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sr_we = 1'b0;
  logic [2:0]  sr_waddr = '0;
  logic [63:0] sr_wdata = '0;
  logic        in_valid = 1'b0;
  logic        out_ready = 1'b0;
  logic [31:0] insn = '0;
  logic [1:0]  form = '0;
  logic [1:0]  size_log2 = '0;
  logic [13:0] long_imm = '0;
  logic [31:0] base_val = '0;
  logic [31:0] idx_val = '0;
  logic [63:0] base_w = '0;
  logic [63:0] idx_w = '0;
  logic        wide_mode = 1'b0;
  logic        phys_mode = 1'b0;

  logic        in_ready, out_valid, wb_en;
  logic [63:0] gva;
  logic [4:0]  wb_reg;
  logic [31:0] wb_data;
  logic        in_ready_w, out_valid_w, wb_en_w;
  logic [63:0] gva_w;
  logic [4:0]  wb_reg_w;
  logic [63:0] wb_data_w;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gva_gen uut (
    .clk(clk), .rst_n(rst_n), .sr_we(sr_we), .sr_waddr(sr_waddr), .sr_wdata(sr_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .insn(insn), .form(form),
    .size_log2(size_log2), .long_imm(long_imm), .base_val(base_val), .idx_val(idx_val),
    .wide_mode(wide_mode), .phys_mode(phys_mode), .out_valid(out_valid),
    .out_ready(out_ready), .gva(gva), .wb_en(wb_en), .wb_reg(wb_reg), .wb_data(wb_data)
  );

  gva_gen #(.REG_W(64)) uut_w (
    .clk(clk), .rst_n(rst_n), .sr_we(sr_we), .sr_waddr(sr_waddr), .sr_wdata(sr_wdata),
    .in_valid(in_valid), .in_ready(in_ready_w), .insn(insn), .form(form),
    .size_log2(size_log2), .long_imm(long_imm), .base_val(base_w), .idx_val(idx_w),
    .wide_mode(wide_mode), .phys_mode(phys_mode), .out_valid(out_valid_w),
    .out_ready(out_ready), .gva(gva_w), .wb_en(wb_en_w), .wb_reg(wb_reg_w), .wb_data(wb_data_w)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    form = v.form; insn = v.insn; size_log2 = v.size; long_imm = v.imm;
    base_val = v.base; idx_val = v.idx; base_w = {32'h0, v.base}; idx_w = {32'h0, v.idx};
    wide_mode = v.wide; phys_mode = v.phys; in_valid = 1'b1;
    #1;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // reset state: space registers zero (R14)
    repeat (2) @(negedge clk);
    form = 2'd1; insn = mk(2'd1, 5'd3, 5'd0, 1'b0, 1'b0); base_val = 32'h10;
    in_valid = 1'b0; out_ready = 1'b1;
    #1;
    chk("R14 reset space zero", gva, 64'h10);
    chk("R14 valid idle", {63'h0, out_valid}, 64'h0);
    chk("R14 ready pass", {63'h0, in_ready}, 64'h1);
    chk("R6 no wb when idle", {63'h0, wb_en}, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      sr_we = 1'b1; sr_waddr = 3'(k); sr_wdata = sr_val(k);
    end
    @(negedge clk);
    sr_we = 1'b0;
    // R14 write took effect, explicit read of space 2
    in_valid = 1'b1; out_ready = 1'b0; insn = mk(2'd2, 5'd3, 5'd0, 1'b0, 1'b0);
    #1;
    chk("R14 space written", gva, 64'h0000_0200_0000_0010);
    chk("R14 valid pass", {63'h0, out_valid}, 64'h1);
    chk("R14 ready low pass", {63'h0, in_ready}, 64'h0);
    out_ready = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      chk($sformatf("R%0d gva vec %0d", TBL[i].rq, i), gva, TBL[i].gva);
      chk($sformatf("R6 wb_en vec %0d", i), {63'h0, wb_en}, {63'h0, TBL[i].wbe});
      if (TBL[i].wbe) begin
        chk($sformatf("R%0d wb_data vec %0d", TBL[i].rq, i), {32'h0, wb_data}, {32'h0, TBL[i].wbd});
        chk($sformatf("R6 wb_reg vec %0d", i), {59'h0, wb_reg}, {59'h0, TBL[i].insn[25:21]});
      end
    end

    // R12 wide mode at 64-bit registers
    @(negedge clk);
    form = 2'd1; insn = mk(2'd1, 5'd3, 5'd0, 1'b0, 1'b0); phys_mode = 1'b0;
    base_w = 64'hFFFF_0000_0000_0010; wide_mode = 1'b1;
    #1;
    chk("R12 wide clears top bits", gva_w, 64'h3FFF_0100_0000_0010);
    wide_mode = 1'b0;
    #1;
    chk("R12 narrow keeps top bits", gva_w, 64'hFFFF_0100_0000_0010);
    insn = mk(2'd0, 5'd3, 5'd0, 1'b0, 1'b0); wide_mode = 1'b1;
    #1;
    chk("R10 implicit from bit 63:62", gva_w, 64'h3FFF_0700_0000_0010);
    phys_mode = 1'b1;
    #1;
    chk("R13 phys wide", gva_w, 64'h3FFF_0000_0000_0010);

    // R14 idle request
    in_valid = 1'b0; phys_mode = 1'b0; wide_mode = 1'b0;
    insn = mk(2'd1, 5'd3, 5'd1, 1'b1, 1'b1);
    #1;
    chk("R6 idle with modify bit", {63'h0, wb_en}, 64'h0);
    chk("R14 out_valid low", {63'h0, out_valid}, 64'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule